// File: doc/BRIEF.md
# Posted Write Queue Flow Controller

This block sits between a host-side target port and a local bus master and queues host writes so that the host transaction finishes as soon as the word is stored. Each queued word is kept together with its byte enables, its address and a flag that marks whether it starts a new local burst. The local side requests the local bus, waits for the grant and hands the words out in arrival order.

Two configuration inputs set the policy at the edges of the queue. When the queue is full, the host is either held with wait states or told to disconnect and retry. When the queue runs empty, the local bus request is either kept, so the bus stays parked for the next write, or dropped at once. Every accepted write also pulses a flush strobe so the read path discards any pending delayed-read data.

Top module: `pw_fifo_ctrl`

## Requirements
- R1: While the queue holds fewer than DEPTH words, a host write with `hw_valid_i` high is accepted in the same cycle (`hw_ready_o`=1, `hw_wait_o`=0, `hw_retry_o`=0), with no dependence on the local bus state.
- R2: With `cfg_wait_full_i`=1 and the queue full, a host write sees `hw_wait_o`=1, `hw_ready_o`=0 and `hw_retry_o`=0, and is not stored.
- R3: With `cfg_wait_full_i`=0 and the queue full, a host write sees `hw_retry_o`=1, `hw_ready_o`=0 and `hw_wait_o`=0, and is not stored.
- R4: `rd_flush_o` is high in exactly the cycles in which a host write is accepted.
- R5: The queue holds up to DEPTH words and presents them on `lb_addr_o`/`lb_data_o`/`lb_be_o` in arrival order, each removed at a clock edge where `lb_valid_o` and `lb_ack_i` are both high.
- R6: `lb_start_o` is high with `lb_valid_o` for the first word sent after a new grant, and for any word whose address differs from the previously queued word's address plus DATA_W/8; otherwise it is low.
- R7: `lb_req_o` rises in the cycle after a write is accepted into an empty queue while the bus is released; `lb_valid_o` is high only while both `lb_req_o` and `lb_grant_i` are high.
- R8: With `cfg_keep_bus_i`=1 and the grant held, `lb_req_o` stays high while the queue is empty.
- R9: With `cfg_keep_bus_i`=0, `lb_req_o` is low in the first cycle after the edge that leaves the queue empty with no new write arriving.
- R10: After reset, `lb_req_o`, `lb_valid_o`, `lb_start_o` are low, and with no host write presented `hw_ready_o`, `hw_wait_o`, `hw_retry_o` and `rd_flush_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wait_full_i | input | 1 | 1: wait states on full queue, 0: disconnect |
| cfg_keep_bus_i | input | 1 | 1: keep local bus request when queue empty |
| hw_valid_i | input | 1 | Host write word present |
| hw_addr_i | input | ADDR_W | Host write byte address |
| hw_data_i | input | DATA_W | Host write data |
| hw_be_i | input | DATA_W/8 | Host write byte enables |
| hw_ready_o | output | 1 | Host write accepted this cycle |
| hw_wait_o | output | 1 | Host held with a wait state |
| hw_retry_o | output | 1 | Host told to disconnect and retry |
| rd_flush_o | output | 1 | Flush pending delayed-read data |
| lb_req_o | output | 1 | Local bus hold request |
| lb_grant_i | input | 1 | Local bus granted |
| lb_valid_o | output | 1 | Local word presented |
| lb_ack_i | input | 1 | Local side takes the presented word |
| lb_addr_o | output | ADDR_W | Local word address |
| lb_data_o | output | DATA_W | Local word data |
| lb_be_o | output | DATA_W/8 | Local word byte enables |
| lb_start_o | output | 1 | Presented word starts a new local burst |

## Verification
The bench builds the block with its defaults, DEPTH=8, DATA_W=32 and ADDR_W=32, so an eight-entry vector table fills the queue exactly and brings both full-queue policies within reach with no extra padding writes. The 32-bit data width fixes the address step for burst continuity at 4, so the table mixes contiguous runs, jumps and a gap of 8 to drive the start flag both ways. The keep-bus case parks the bus, then pushes a contiguous word to show that no new burst starts while the grant persists.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    LB_IDLE = 2'd0,
    LB_REQ  = 2'd1,
    LB_XFER = 2'd2
  } lb_state_e;
endpackage

// File: rtl/pw_fifo_mem.sv
module pw_fifo_mem #(
  parameter int W     = 69,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         drain_empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign cnt_d         = cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
  assign full_o        = (cnt_q == CNT_W'(DEPTH));
  assign empty_o       = (cnt_q == '0);
  assign drain_empty_o = (cnt_d == '0);
  assign head_o        = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (push_i) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk_i) disable iff (!rst_ni) push_i |-> !full_o);  // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) pop_i |-> !empty_o);  // R5
endmodule

// File: rtl/pw_host_if.sv
module pw_host_if #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wait_full_i,
  input  logic              hw_valid_i,
  input  logic [ADDR_W-1:0] hw_addr_i,
  input  logic              full_i,
  output logic              hw_ready_o,
  output logic              hw_wait_o,
  output logic              hw_retry_o,
  output logic              rd_flush_o,
  output logic              push_o,
  output logic              new_burst_o
);
  logic [ADDR_W-1:0] last_addr_q;
  logic              last_vld_q;

  assign push_o      = hw_valid_i && !full_i;
  assign hw_ready_o  = push_o;
  assign hw_wait_o   = hw_valid_i && full_i && cfg_wait_full_i;
  assign hw_retry_o  = hw_valid_i && full_i && !cfg_wait_full_i;
  // any accepted write invalidates prefetched read data
  assign rd_flush_o  = push_o;
  assign new_burst_o = !last_vld_q || (hw_addr_i != last_addr_q + ADDR_W'(BE_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_q <= '0;
      last_vld_q  <= 1'b0;
    end else if (push_o) begin
      last_addr_q <= hw_addr_i;
      last_vld_q  <= 1'b1;
    end
  end

  AST_FULL_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni) full_i |-> !hw_ready_o);  // R2
  AST_RETRY_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni) hw_retry_o |-> full_i);  // R3
endmodule

// File: rtl/pw_local_ctl.sv
module pw_local_ctl
  import pw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_keep_bus_i,
  input  logic empty_i,
  input  logic drain_empty_i,
  input  logic head_new_burst_i,
  input  logic lb_grant_i,
  input  logic lb_ack_i,
  output logic lb_req_o,
  output logic lb_valid_o,
  output logic lb_start_o,
  output logic pop_o
);
  lb_state_e state_q, state_d;
  logic      fresh_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LB_IDLE: if (!drain_empty_i) state_d = LB_REQ;
      LB_REQ:  if (lb_grant_i)     state_d = LB_XFER;
      LB_XFER: begin
        if (!lb_grant_i)                          state_d = drain_empty_i ? LB_IDLE : LB_REQ;
        else if (drain_empty_i && !cfg_keep_bus_i) state_d = LB_IDLE;
      end
      default: state_d = LB_IDLE;
    endcase
  end

  assign lb_req_o   = (state_q != LB_IDLE);
  assign lb_valid_o = (state_q == LB_XFER) && lb_grant_i && !empty_i;
  assign pop_o      = lb_valid_o && lb_ack_i;
  // first word after a grant always opens a burst
  assign lb_start_o = lb_valid_o && (head_new_burst_i || fresh_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LB_IDLE;
      fresh_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == LB_REQ && lb_grant_i) fresh_q <= 1'b1;
      else if (pop_o)                     fresh_q <= 1'b0;
    end
  end

  AST_VALID_NEEDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_valid_o |-> (lb_grant_i && lb_req_o));  // R7
endmodule

// File: rtl/pw_fifo_ctrl.sv
module pw_fifo_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_wait_full_i,
  input  logic                cfg_keep_bus_i,
  input  logic                hw_valid_i,
  input  logic [ADDR_W-1:0]   hw_addr_i,
  input  logic [DATA_W-1:0]   hw_data_i,
  input  logic [DATA_W/8-1:0] hw_be_i,
  output logic                hw_ready_o,
  output logic                hw_wait_o,
  output logic                hw_retry_o,
  output logic                rd_flush_o,
  output logic                lb_req_o,
  input  logic                lb_grant_i,
  output logic                lb_valid_o,
  input  logic                lb_ack_i,
  output logic [ADDR_W-1:0]   lb_addr_o,
  output logic [DATA_W-1:0]   lb_data_o,
  output logic [DATA_W/8-1:0] lb_be_o,
  output logic                lb_start_o
);
  localparam int BE_W  = DATA_W / 8;
  localparam int ENT_W = 1 + BE_W + ADDR_W + DATA_W;

  logic             push, pop, full, empty, drain_empty, new_burst;
  logic [ENT_W-1:0] wr_ent, head_ent;
  logic             head_new_burst;

  pw_host_if #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_host (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cfg_wait_full_i (cfg_wait_full_i),
    .hw_valid_i      (hw_valid_i),
    .hw_addr_i       (hw_addr_i),
    .full_i          (full),
    .hw_ready_o      (hw_ready_o),
    .hw_wait_o       (hw_wait_o),
    .hw_retry_o      (hw_retry_o),
    .rd_flush_o      (rd_flush_o),
    .push_o          (push),
    .new_burst_o     (new_burst)
  );

  assign wr_ent = {new_burst, hw_be_i, hw_addr_i, hw_data_i};

  pw_fifo_mem #(.W(ENT_W), .DEPTH(DEPTH)) u_mem (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .push_i        (push),
    .wdata_i       (wr_ent),
    .pop_i         (pop),
    .head_o        (head_ent),
    .full_o        (full),
    .empty_o       (empty),
    .drain_empty_o (drain_empty)
  );

  assign {head_new_burst, lb_be_o, lb_addr_o, lb_data_o} = head_ent;

  pw_local_ctl u_local (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .cfg_keep_bus_i   (cfg_keep_bus_i),
    .empty_i          (empty),
    .drain_empty_i    (drain_empty),
    .head_new_burst_i (head_new_burst),
    .lb_grant_i       (lb_grant_i),
    .lb_ack_i         (lb_ack_i),
    .lb_req_o         (lb_req_o),
    .lb_valid_o       (lb_valid_o),
    .lb_start_o       (lb_start_o),
    .pop_o            (pop)
  );

  AST_KEEP_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_keep_bus_i && lb_req_o && lb_grant_i && empty) |=> lb_req_o);  // R8
  AST_RELEASE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_keep_bus_i && empty && !push) |=> !lb_req_o);  // R9
endmodule

// File: tb/pw_fifo_ctrl_tb_top.sv
`timescale 1ns/1ps
module pw_fifo_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wait, cfg_keep, hw_valid, lb_grant, lb_ack;
  logic [31:0] hw_addr, hw_data;
  logic [3:0]  hw_be;
  logic        hw_ready, hw_wait, hw_retry, rd_flush, lb_req, lb_valid, lb_start;
  logic [31:0] lb_addr, lb_data;
  logic [3:0]  lb_be;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pw_fifo_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wait_full_i(cfg_wait), .cfg_keep_bus_i(cfg_keep),
    .hw_valid_i(hw_valid), .hw_addr_i(hw_addr), .hw_data_i(hw_data), .hw_be_i(hw_be),
    .hw_ready_o(hw_ready), .hw_wait_o(hw_wait), .hw_retry_o(hw_retry), .rd_flush_o(rd_flush),
    .lb_req_o(lb_req), .lb_grant_i(lb_grant), .lb_valid_o(lb_valid), .lb_ack_i(lb_ack),
    .lb_addr_o(lb_addr), .lb_data_o(lb_data), .lb_be_o(lb_be), .lb_start_o(lb_start)
  );

  // {exp_start, be, addr, data}
  localparam logic [68:0] VEC [8] = '{
    {1'b1, 4'hF, 32'h0000_0100, 32'hA000_0001},
    {1'b0, 4'h3, 32'h0000_0104, 32'hA000_0002},
    {1'b0, 4'hC, 32'h0000_0108, 32'hA000_0003},
    {1'b1, 4'hF, 32'h0000_0200, 32'hB000_0004},
    {1'b0, 4'h1, 32'h0000_0204, 32'hB000_0005},
    {1'b1, 4'hF, 32'h0000_0300, 32'hC000_0006},
    {1'b1, 4'h8, 32'h0000_0308, 32'hC000_0007},
    {1'b0, 4'hF, 32'h0000_030C, 32'hC000_0008}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_edge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cfg_wait = 1'b1; cfg_keep = 1'b0; hw_valid = 1'b0; lb_grant = 1'b0; lb_ack = 1'b0;
    hw_addr = '0; hw_data = '0; hw_be = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 req", 32'(lb_req), 0);
    chk("R10 valid", 32'(lb_valid), 0);
    chk("R10 start", 32'(lb_start), 0);
    chk("R10 ready", 32'(hw_ready), 0);
    chk("R10 wait/retry", 32'({hw_wait, hw_retry}), 0);
    chk("R10 flush", 32'(rd_flush), 0);

    // fill the queue from the table with the bus not granted
    for (int i = 0; i < 8; i++) begin
      drive_edge();
      hw_valid = 1'b1;
      hw_be = VEC[i][67:64]; hw_addr = VEC[i][63:32]; hw_data = VEC[i][31:0];
      @(negedge clk);
      chk("R1 ready", 32'(hw_ready), 1);
      chk("R1 no wait/retry", 32'({hw_wait, hw_retry}), 0);
      chk("R4 flush on accept", 32'(rd_flush), 1);
      if (i == 1) chk("R7 req after first write", 32'(lb_req), 1);
      if (i > 0) chk("R7 no valid without grant", 32'(lb_valid), 0);
    end
    drive_edge();
    hw_valid = 1'b0;
    @(negedge clk);
    chk("R4 no flush when idle", 32'(rd_flush), 0);

    // full queue policies
    drive_edge();
    hw_valid = 1'b1; hw_addr = 32'h500; hw_data = 32'hDEAD_0000; cfg_wait = 1'b1;
    @(negedge clk);
    chk("R2 wait on full", 32'(hw_wait), 1);
    chk("R2 not ready", 32'(hw_ready), 0);
    chk("R2 no retry", 32'(hw_retry), 0);
    chk("R4 no flush when full", 32'(rd_flush), 0);
    drive_edge();
    cfg_wait = 1'b0;
    @(negedge clk);
    chk("R3 retry on full", 32'(hw_retry), 1);
    chk("R3 not ready", 32'(hw_ready), 0);
    chk("R3 no wait", 32'(hw_wait), 0);
    drive_edge();
    hw_valid = 1'b0; cfg_wait = 1'b1;

    // drain in order
    lb_grant = 1'b1; lb_ack = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (lb_valid) break;
    end
    for (int i = 0; i < 8; i++) begin
      chk("R5 valid", 32'(lb_valid), 1);
      chk("R5 addr", lb_addr, VEC[i][63:32]);
      chk("R5 data", lb_data, VEC[i][31:0]);
      chk("R5 be", 32'(lb_be), 32'(VEC[i][67:64]));
      chk("R6 burst start", 32'(lb_start), 32'(VEC[i][68]));
      @(negedge clk);
    end
    chk("R9 release on drain", 32'(lb_req), 0);
    chk("R5 empty after drain", 32'(lb_valid), 0);

    // keep-bus parking
    drive_edge();
    cfg_keep = 1'b1; hw_valid = 1'b1; hw_addr = 32'h400; hw_data = 32'h1234_5678; hw_be = 4'h3;
    @(negedge clk);
    chk("R1 ready keep", 32'(hw_ready), 1);
    drive_edge();
    hw_valid = 1'b0;
    @(negedge clk);
    chk("R7 req rises", 32'(lb_req), 1);
    chk("R7 no valid in request", 32'(lb_valid), 0);
    @(negedge clk);
    chk("R5 parked word", lb_data, 32'h1234_5678);
    chk("R6 start after grant", 32'(lb_start), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 keep request", 32'(lb_req), 1);
      chk("R8 no valid while empty", 32'(lb_valid), 0);
    end
    drive_edge();
    hw_valid = 1'b1; hw_addr = 32'h404; hw_data = 32'h8765_4321; hw_be = 4'hF;
    drive_edge();
    hw_valid = 1'b0;
    @(negedge clk);
    chk("R5 contiguous word", lb_data, 32'h8765_4321);
    chk("R6 no start while parked", 32'(lb_start), 0);
    drive_edge();
    cfg_keep = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 release after keep cleared", 32'(lb_req), 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule